// File: doc/BRIEF.md
# Split-Bank Byte/Word Access Aligner

This block connects a load/store requester to a 16-bit memory made of two byte-wide banks. Bytes at even addresses sit in the low bank, which carries data bits 7:0. Bytes at odd addresses sit in the high bank, which carries bits 15:8. The requester may ask for a byte or a word at any byte address, for a read or a write. The block turns each request into one or two bank cycles. It steers the bytes between the lanes and the requester in little-endian order, and it pulses a completion flag when the operation is finished.

A word at an even address takes one bank cycle with both lanes enabled. A word at an odd address is split into two bank cycles. The first uses the high lane of the addressed memory word. The second uses the low lane of the following memory word. The low result byte always comes from the requested address. The memory is assumed to return read data combinationally in the same cycle as the bank strobe, and to commit writes on the clock edge that ends a strobed cycle.

Top module: `split_bank_aligner`

## Requirements
- R1: While reset is held and after it is released with no request, `busy`, `done` and `mem_en` are 0 and `req_ready` is 1.
- R2: A word access at an even byte address A, accepted in cycle T, produces exactly one bank cycle in T+1. That cycle has `mem_be` = 2'b11 and `mem_waddr` = A>>1. For a read, `rdata` equals the memory word unchanged.
- R3: A word access at an odd byte address A produces two bank cycles, in T+1 and T+2. The first has `mem_be` = 2'b10 and `mem_waddr` = A>>1. The second has `mem_be` = 2'b01 and `mem_waddr` = (A>>1)+1.
- R4: For an odd-address word read, `rdata[7:0]` is the byte at A (the high lane of the first cycle) and `rdata[15:8]` is the byte at A+1 (the low lane of the second cycle). With bytes FF, AB, 12, 55 at addresses 0 to 3, a read at 0 returns 16'hABFF and a read at 1 returns 16'h12AB.
- R5: A byte access enables a single lane: 2'b10 (bits 15:8) for an odd address and 2'b01 (bits 7:0) for an even one. A byte read returns that lane's byte in `rdata[7:0]`, with `rdata[15:8]` = 0.
- R6: Writes assert `mem_we` only during their bank cycles. An even word writes `req_wdata` unchanged on both lanes. An odd word puts `req_wdata[7:0]` on lane 15:8 in the first cycle and `req_wdata[15:8]` on lane 7:0 in the second. A byte write puts `req_wdata[7:0]` on the selected lane. `rdata` is 0 at the completion of a write.
- R7: `done` is high for exactly one cycle, the cycle after the last bank cycle (T+2 for one bank cycle, T+3 for two). `busy` is high from T+1 through the `done` cycle, and a request is accepted only when `req_valid` and `req_ready` are both high.
- R8: While `busy` is high, `req_ready` is 0. A request presented then is ignored and produces no bank cycle. With no accepted request, no bank cycle occurs.
- R9: An odd word at the highest byte address wraps. Its second bank cycle uses `mem_waddr` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = word (16 bits), 0 = byte |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 16 | Write data, byte in bits 7:0, word little-endian |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Operation in progress |
| rdata | output | 16 | Assembled read result, valid while done is high |
| mem_en | output | 1 | Bank cycle strobe |
| mem_we | output | 1 | Bank cycle is a write |
| mem_waddr | output | ADDR_W-1 | Memory word address |
| mem_be | output | 2 | Lane enables, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| mem_wdata | output | 16 | Lane write data |
| mem_rdata | input | 16 | Lane read data, valid in the strobed cycle |

## Verification
Counting from the acceptance cycle T, the first bank strobe is due in T+1 and any second strobe in T+2. `done` with `rdata` is due in T+2 or T+3, and the block is idle in the cycle after `done`. The bench reference model queues one expected record per cycle at the falling edge of T and pops one record at every later falling edge. Each cycle's outputs are therefore compared against the cycle in which they are due. Outside a queued operation the model expects no strobe, which is how ignored requests are caught. It decides acceptance from its own notion of readiness, not from the design's.

// File: rtl/sba_pkg.sv
package sba_pkg;

  localparam int BYTE_W = 8;
  localparam int LANES  = 2;
  localparam int BUS_W  = BYTE_W * LANES;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FIRST  = 2'd1,
    ST_SECOND = 2'd2,
    ST_DONE   = 2'd3
  } sba_state_e;

  localparam logic [LANES-1:0] SECOND_BE = 2'b01;

  // A word whose low byte sits in the high bank straddles two memory words.
  function automatic logic needs_split(input logic word, input logic odd);
    return word & odd;
  endfunction

  function automatic logic [LANES-1:0] first_be(input logic word, input logic odd);
    if (odd)       return 2'b10;
    else if (word) return 2'b11;
    else           return 2'b01;
  endfunction

  // Byte driven on a lane during the first bank cycle.
  function automatic logic [BYTE_W-1:0] first_lane_src(input int lane, input logic odd,
                                                       input logic [BUS_W-1:0] wd);
    if (lane == 0) return wd[BYTE_W-1:0];
    return odd ? wd[BYTE_W-1:0] : wd[BUS_W-1:BYTE_W];
  endfunction

  // Byte driven on a lane during the second bank cycle (low lane only).
  function automatic logic [BYTE_W-1:0] second_lane_src(input int lane,
                                                        input logic [BUS_W-1:0] wd);
    if (lane == 0) return wd[BUS_W-1:BYTE_W];
    return '0;
  endfunction

  // Right-aligned result after the first bank cycle of a read.
  function automatic logic [BUS_W-1:0] first_capture(input logic word, input logic odd,
                                                     input logic [BUS_W-1:0] rd);
    if (odd)       return {{BYTE_W{1'b0}}, rd[BUS_W-1:BYTE_W]};
    else if (word) return rd;
    else           return {{BYTE_W{1'b0}}, rd[BYTE_W-1:0]};
  endfunction

endpackage

// File: rtl/sba_sequencer.sv
module sba_sequencer
  import sba_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_word,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BUS_W-1:0]  req_wdata,
  output logic              req_ready,
  output logic              accept,
  output logic              bank_first,
  output logic              bank_second,
  output logic              done,
  output logic              busy,
  output logic              op_write,
  output logic              op_word,
  output logic [ADDR_W-1:0] op_addr,
  output logic [BUS_W-1:0]  op_wdata
);

  sba_state_e state_q, state_d;
  logic       split;

  assign split = needs_split(op_word, op_addr[0]);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (accept) state_d = ST_FIRST;
      ST_FIRST:  state_d = split ? ST_SECOND : ST_DONE;
      ST_SECOND: state_d = ST_DONE;
      ST_DONE:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      op_write <= 1'b0;
      op_word  <= 1'b0;
      op_addr  <= '0;
      op_wdata <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        op_write <= req_write;
        op_word  <= req_word;
        op_addr  <= req_addr;
        op_wdata <= req_wdata;
      end
    end
  end

  assign busy        = (state_q != ST_IDLE);
  assign req_ready   = ~busy;
  assign accept      = req_valid & req_ready;
  assign bank_first  = (state_q == ST_FIRST);
  assign bank_second = (state_q == ST_SECOND);
  assign done        = (state_q == ST_DONE);

endmodule

// File: rtl/sba_lane_steer.sv
module sba_lane_steer
  import sba_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              bank_first,
  input  logic              bank_second,
  input  logic              op_write,
  input  logic              op_word,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [BUS_W-1:0]  op_wdata,
  input  logic [BUS_W-1:0]  mem_rdata,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-2:0] mem_waddr,
  output logic [LANES-1:0]  mem_be,
  output logic [BUS_W-1:0]  mem_wdata,
  output logic [BUS_W-1:0]  rdata
);

  localparam int WA_W = ADDR_W - 1;

  logic              odd;
  logic [WA_W-1:0]   base_wa;
  logic [BUS_W-1:0]  result_q;

  assign odd     = op_addr[0];
  assign base_wa = op_addr[ADDR_W-1:1];

  assign mem_en    = bank_first | bank_second;
  assign mem_we    = mem_en & op_write;
  assign mem_waddr = bank_second ? WA_W'(base_wa + 1'b1) : base_wa;

  always_comb begin
    if (bank_first)       mem_be = first_be(op_word, odd);
    else if (bank_second) mem_be = SECOND_BE;
    else                  mem_be = '0;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_comb begin
      if (bank_first)
        mem_wdata[l*BYTE_W +: BYTE_W] = first_lane_src(l, odd, op_wdata);
      else if (bank_second)
        mem_wdata[l*BYTE_W +: BYTE_W] = second_lane_src(l, op_wdata);
      else
        mem_wdata[l*BYTE_W +: BYTE_W] = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result_q <= '0;
    end else if (accept) begin
      result_q <= '0;
    end else if (bank_first && !op_write) begin
      result_q <= first_capture(op_word, odd, mem_rdata);
    end else if (bank_second && !op_write) begin
      result_q[BUS_W-1:BYTE_W] <= mem_rdata[BYTE_W-1:0];
    end
  end

  assign rdata = result_q;

endmodule

// File: rtl/split_bank_aligner.sv
module split_bank_aligner
  import sba_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_word,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [15:0]       req_wdata,
  output logic              done,
  output logic              busy,
  output logic [15:0]       rdata,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-2:0] mem_waddr,
  output logic [1:0]        mem_be,
  output logic [15:0]       mem_wdata,
  input  logic [15:0]       mem_rdata
);

  // Internal events brought out by name for the bound checker.
  logic              accept;
  logic              bank_first;
  logic              bank_second;
  logic              op_write;
  logic              op_word;
  logic [ADDR_W-1:0] op_addr;
  logic [BUS_W-1:0]  op_wdata;

  sba_sequencer #(.ADDR_W(ADDR_W)) seq_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_word    (req_word),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .req_ready   (req_ready),
    .accept      (accept),
    .bank_first  (bank_first),
    .bank_second (bank_second),
    .done        (done),
    .busy        (busy),
    .op_write    (op_write),
    .op_word     (op_word),
    .op_addr     (op_addr),
    .op_wdata    (op_wdata)
  );

  sba_lane_steer #(.ADDR_W(ADDR_W)) steer_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept      (accept),
    .bank_first  (bank_first),
    .bank_second (bank_second),
    .op_write    (op_write),
    .op_word     (op_word),
    .op_addr     (op_addr),
    .op_wdata    (op_wdata),
    .mem_rdata   (mem_rdata),
    .mem_en      (mem_en),
    .mem_we      (mem_we),
    .mem_waddr   (mem_waddr),
    .mem_be      (mem_be),
    .mem_wdata   (mem_wdata),
    .rdata       (rdata)
  );

endmodule

// File: rtl/sba_checker.sv
module sba_checker #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              busy,
  input logic              done,
  input logic              mem_en,
  input logic              mem_we,
  input logic [1:0]        mem_be,
  input logic [ADDR_W-2:0] mem_waddr,
  input logic              bank_second
);

  localparam int WA_W = ADDR_W - 1;

  assert_lane_enabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> (mem_be != 2'b00));

  assert_write_in_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_en);

  assert_second_next_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bank_second |-> (mem_be == 2'b01) && (mem_waddr == WA_W'($past(mem_waddr) + 1'b1)));

  assert_second_after_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bank_second |-> $past(mem_en) && !$past(bank_second));

  assert_wrap_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_second && ($past(mem_waddr) == {WA_W{1'b1}})) |-> (mem_waddr == '0));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_after_bank_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(mem_en));

  assert_accept_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> busy);

  assert_busy_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_en && !done);

endmodule

bind split_bank_aligner sba_checker #(.ADDR_W(ADDR_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .busy        (busy),
  .done        (done),
  .mem_en      (mem_en),
  .mem_we      (mem_we),
  .mem_be      (mem_be),
  .mem_waddr   (mem_waddr),
  .bank_second (bank_second)
);

// File: tb/split_bank_aligner_tb_top.sv
`timescale 1ns/1ps
module split_bank_aligner_tb_top;

  localparam int AW    = 10;
  localparam int WA    = AW - 1;
  localparam int NBYTE = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic          req_word = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [15:0]   req_wdata = '0;
  logic          req_ready, done, busy, mem_en, mem_we;
  logic [15:0]   rdata, mem_wdata, mem_rdata;
  logic [WA-1:0] mem_waddr;
  logic [1:0]    mem_be;

  int  n_run  = 0;
  int  n_fail = 0;
  bit  finished = 1'b0;

  logic [7:0] mem [NBYTE];

  always #2.5 clk = ~clk;

  split_bank_aligner #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_word(req_word), .req_addr(req_addr),
    .req_wdata(req_wdata), .done(done), .busy(busy), .rdata(rdata),
    .mem_en(mem_en), .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // Behavioural two-bank memory: combinational read, write at the clock edge.
  assign mem_rdata = {mem[{mem_waddr, 1'b1}], mem[{mem_waddr, 1'b0}]};

  always @(posedge clk) begin
    if (mem_en && mem_we) begin
      if (mem_be[0]) mem[{mem_waddr, 1'b0}] <= mem_wdata[7:0];
      if (mem_be[1]) mem[{mem_waddr, 1'b1}] <= mem_wdata[15:8];
    end
  end

  typedef struct {
    logic          en;
    logic          we;
    logic [WA-1:0] wa;
    logic [1:0]    be;
    logic [15:0]   wd;
    logic          dn;
    logic [15:0]   rd;
    string         tag;
  } exp_t;

  exp_t q[$];

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, expv, $time);
    end
  endtask

  // Builds the expected per-cycle records for one accepted request.
  task automatic plan_op(input bit wr, input bit w, input logic [AW-1:0] a,
                         input logic [15:0] d);
    exp_t e;
    bit odd;
    logic [WA-1:0] wa;
    logic [AW-1:0] a1;
    odd = a[0];
    wa  = a[AW-1:1];
    a1  = a + 1'b1;
    e.en = 1; e.we = wr; e.wa = wa; e.dn = 0; e.rd = '0;
    e.be = odd ? 2'b10 : (w ? 2'b11 : 2'b01);
    e.wd = (w && !odd) ? d : (odd ? {d[7:0], 8'h00} : {8'h00, d[7:0]});
    e.tag = wr ? "R6" : ((w && odd) ? "R3" : (w ? "R2" : "R5"));
    q.push_back(e);
    if (w && odd) begin
      e.wa = wa + 1'b1;
      e.be = 2'b01;
      e.wd = {8'h00, d[15:8]};
      e.tag = (wa == {WA{1'b1}}) ? "R9" : (wr ? "R6" : "R3");
      q.push_back(e);
    end
    e.en = 0; e.we = 0; e.dn = 1;
    e.rd = wr ? 16'h0000 : {(w ? mem[a1] : 8'h00), mem[a]};
    e.tag = (w && odd && !wr) ? "R4" : (wr ? "R6" : "R7");
    q.push_back(e);
  endtask

  // Reference model compared on every falling edge.
  always @(negedge clk) begin
    exp_t e;
    bit   busy_exp;
    if (rst_n && !finished) begin
      if (q.size() > 0) begin
        e = q.pop_front();
        busy_exp = 1'b1;
      end else begin
        e.en = 0; e.we = 0; e.wa = '0; e.be = '0; e.wd = '0; e.dn = 0; e.rd = '0;
        e.tag = "R8";
        busy_exp = 1'b0;
      end
      chk(mem_en == e.en, e.tag, "mem_en", 32'(mem_en), 32'(e.en));
      chk(busy == busy_exp, busy_exp ? "R7" : e.tag, "busy", 32'(busy), 32'(busy_exp));
      chk(req_ready == !busy_exp, busy_exp ? "R8" : "R7", "req_ready",
          32'(req_ready), 32'(!busy_exp));
      chk(done == e.dn, "R7", "done", 32'(done), 32'(e.dn));
      if (e.en) begin
        chk(mem_we == e.we, e.tag, "mem_we", 32'(mem_we), 32'(e.we));
        chk(mem_waddr == e.wa, e.tag, "mem_waddr", 32'(mem_waddr), 32'(e.wa));
        chk(mem_be == e.be, e.tag, "mem_be", 32'(mem_be), 32'(e.be));
        if (e.we && e.be[0])
          chk(mem_wdata[7:0] == e.wd[7:0], e.tag, "lane0", 32'(mem_wdata[7:0]), 32'(e.wd[7:0]));
        if (e.we && e.be[1])
          chk(mem_wdata[15:8] == e.wd[15:8], e.tag, "lane1", 32'(mem_wdata[15:8]), 32'(e.wd[15:8]));
      end
      if (e.dn) chk(rdata == e.rd, e.tag, "rdata", 32'(rdata), 32'(e.rd));
      if (req_valid && !busy_exp) plan_op(req_write, req_word, req_addr, req_wdata);
    end
  end

  task automatic do_op(input bit wr, input bit w, input logic [AW-1:0] a,
                       input logic [15:0] d, input bit stray);
    @(posedge clk); #1;
    req_valid = 1; req_write = wr; req_word = w; req_addr = a; req_wdata = d;
    @(posedge clk); #1;
    if (stray) begin
      // R8: a different request offered while the block is busy.
      req_write = 1; req_word = 1; req_addr = a ^ 10'h155; req_wdata = 16'hDEAD;
      @(posedge clk); #1;
    end
    req_valid = 0;
    repeat (5) @(posedge clk);
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    for (int i = 0; i < NBYTE; i++) mem[i] = 8'((i * 37 + 5) & 255);
    mem[0] = 8'hFF; mem[1] = 8'hAB; mem[2] = 8'h12; mem[3] = 8'h55;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk(!busy && !done && !mem_en && req_ready, "R1", "reset outputs",
        {28'h0, busy, done, mem_en, req_ready}, 32'h1);
    @(posedge clk); #1;
    rst_n = 1;
    repeat (3) @(posedge clk);
    do_op(0, 1, 10'd0, 16'h0, 0);        // R2: even word -> ABFF
    do_op(0, 1, 10'd1, 16'h0, 0);        // R3 R4: odd word -> 12AB
    do_op(0, 0, 10'd1, 16'h0, 0);        // R5: odd byte
    do_op(0, 0, 10'd0, 16'h0, 0);        // R5: even byte
    do_op(1, 1, 10'd5, 16'h1234, 0);     // R6: odd word write
    do_op(0, 1, 10'd5, 16'h0, 0);
    do_op(1, 1, 10'd8, 16'hBEEF, 0);     // R6: even word write
    do_op(1, 0, 10'd3, 16'h00C3, 0);     // R6: odd byte write
    do_op(1, 0, 10'd6, 16'h0077, 0);     // R6: even byte write
    do_op(0, 1, 10'd2, 16'h0, 0);
    do_op(0, 1, 10'd6, 16'h0, 0);
    do_op(0, 1, 10'd1023, 16'h0, 0);     // R9: wrap at top
    do_op(1, 1, 10'd1023, 16'hA55A, 0);  // R9: wrapping write
    do_op(0, 1, 10'd1023, 16'h0, 0);
    do_op(0, 1, 10'd11, 16'h0, 1);       // R8: stray request while busy
    do_op(0, 0, 10'd4, 16'h0, 1);        // R8: stray during byte read
    repeat (4) @(posedge clk);
    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL R7 watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

endmodule